// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block predicts the next fetch address for an instruction fetch unit. It holds a direct-mapped table indexed by low word-address bits of the fetch PC. Each entry keeps a valid flag, the complete PC of a branch, that branch's last taken target and a 2-bit saturating direction counter. A lookup is combinational. When the entry is valid, its stored PC equals the fetch PC and the counter's upper bit is set, the stored target is offered as the next PC. In every other case the next PC is the fetch PC plus 4.

When a branch resolves, the back end presents its PC, its real outcome, its real target and the next PC that fetch used for it. The block compares the real next PC against the one that was used. On any difference it raises a redirect in the same cycle, together with the correct address. At the clock edge it then trains the table. On a hit the counter moves toward the outcome and a taken outcome refreshes the target. A taken branch that misses claims the entry and evicts whatever held that index. A not-taken branch that misses leaves the table alone.

Top module: `btb_dir_predict`

## Requirements
- R1: After reset every entry is invalid. Every lookup then reports pred_hit=0 and pred_taken=0, and pred_next_pc equals fetch_pc+4.
- R2: When the indexed entry is valid, its stored PC equals fetch_pc and its counter is 2 or 3, the lookup gives pred_hit=1, pred_taken=1 and pred_next_pc equal to the stored target.
- R3: When the entry hits but its counter is 0 or 1, the lookup gives pred_hit=1, pred_taken=0 and pred_next_pc equal to fetch_pc+4.
- R4: The index is fetch_pc[IDX_W+1:2]. A valid entry at that index whose stored PC differs from fetch_pc is treated as a miss: pred_next_pc equals fetch_pc+4.
- R5: A resolved taken branch that misses installs its PC and target, with the counter set to 2 (weakly taken). A following lookup of that PC therefore predicts taken.
- R6: A resolved not-taken branch that misses changes no entry.
- R7: On a hit, a taken outcome increments the counter and saturates at 3. A not-taken outcome decrements it and saturates at 0.
- R8: A taken outcome on a hit replaces the stored target with upd_target.
- R9: The redirect output is combinational. It is high exactly when upd_valid is set and the correct next PC differs from upd_pred_next. The correct next PC is upd_target when the branch was taken, otherwise upd_pc+4. redirect_pc always carries that correct next PC.
- R10: A taken branch that misses at an index held by a different PC evicts that entry. The old PC then misses.
- R11: A training update takes effect at the clock edge. A lookup in the same cycle as the update still sees the old table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | AW | PC being fetched |
| pred_hit | output | 1 | Valid entry with matching stored PC |
| pred_taken | output | 1 | Hit and counter predicts taken |
| pred_next_pc | output | AW | Predicted next fetch PC |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | AW | PC of the resolved branch |
| upd_taken | input | 1 | Real direction of the branch |
| upd_target | input | AW | Real target of the branch |
| upd_pred_next | input | AW | Next PC fetch used after this branch |
| redirect | output | 1 | Prediction was wrong, fetch must restart |
| redirect_pc | output | AW | Correct next PC |

## Verification
The case that is hardest to reach from the ports is the counter at its two saturation limits. At those limits a counter that wraps and one that saturates produce the same prediction until one more update arrives. The stimulus drives one branch PC repeatedly with a run of not-taken outcomes past zero, then one taken outcome. A saturating counter must still predict not-taken at that point. It then drives a run of taken outcomes past three, then one not-taken outcome, after which the branch must still predict taken. Eviction is reached by training two PCs that share an index. A same-cycle lookup during an update shows the edge at which training becomes visible.

// File: rtl/btb_dir_predict.sv
module btb_dir_predict #(
  parameter int AW    = 32,
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_pc,
  output logic          pred_hit,
  output logic          pred_taken,
  output logic [AW-1:0] pred_next_pc,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic [AW-1:0] upd_target,
  input  logic [AW-1:0] upd_pred_next,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [AW-1:0] STEP = AW'(4);

  logic          valid_q [DEPTH];
  logic [AW-1:0] tag_q   [DEPTH];
  logic [AW-1:0] tgt_q   [DEPTH];
  logic [1:0]    ctr_q   [DEPTH];

  logic [IDX_W-1:0] f_idx, u_idx;
  logic             u_hit;

  assign f_idx = fetch_pc[IDX_W+1:2];
  assign u_idx = upd_pc[IDX_W+1:2];

  assign pred_hit     = valid_q[f_idx] && (tag_q[f_idx] == fetch_pc);
  assign pred_taken   = pred_hit && ctr_q[f_idx][1];
  assign pred_next_pc = pred_taken ? tgt_q[f_idx] : fetch_pc + STEP;

  assign u_hit       = valid_q[u_idx] && (tag_q[u_idx] == upd_pc);
  assign redirect_pc = upd_taken ? upd_target : upd_pc + STEP;
  assign redirect    = upd_valid && (redirect_pc != upd_pred_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        tgt_q[i]   <= '0;
        ctr_q[i]   <= 2'b00;
      end
    end else if (upd_valid) begin
      if (u_hit) begin
        if (upd_taken) begin
          tgt_q[u_idx] <= upd_target;
          if (ctr_q[u_idx] != 2'b11) ctr_q[u_idx] <= ctr_q[u_idx] + 2'b01;
        end else if (ctr_q[u_idx] != 2'b00) begin
          ctr_q[u_idx] <= ctr_q[u_idx] - 2'b01;
        end
      end else if (upd_taken) begin
        valid_q[u_idx] <= 1'b1;
        tag_q[u_idx]   <= upd_pc;
        tgt_q[u_idx]   <= upd_target;
        ctr_q[u_idx]   <= 2'b10;
      end
    end
  end

  assert_taken_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

  assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> pred_next_pc == fetch_pc + STEP);

  assert_alloc_weak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && !u_hit) |=>
      (valid_q[$past(u_idx)] && ctr_q[$past(u_idx)] == 2'b10));

  assert_no_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !u_hit) |=>
      (valid_q[$past(u_idx)] == $past(valid_q[u_idx])));

  assert_sat_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && u_hit && ctr_q[u_idx] == 2'b11) |=>
      ctr_q[$past(u_idx)] == 2'b11);

  assert_sat_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && u_hit && ctr_q[u_idx] == 2'b00) |=>
      ctr_q[$past(u_idx)] == 2'b00);

  assert_redirect_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !redirect);
endmodule

// File: tb/test_btb_dir_predict.sv
`timescale 1ns/100ps
module test_btb_dir_predict;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_next_pc;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic [31:0] upd_target;
  logic [31:0] upd_pred_next;
  logic        redirect;
  logic [31:0] redirect_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  btb_dir_predict #(.AW(32), .IDX_W(4)) i_btb_dir_predict (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_pred_next(upd_pred_next),
    .redirect(redirect), .redirect_pc(redirect_pc));

  typedef struct packed {
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] utgt;
    logic [31:0] upn;
    logic        rd;
    logic [31:0] lpc;
    logic        hit;
    logic        tkn;
    logic [31:0] nxt;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h100, 1'b0, 32'h0,    32'h104, 1'b0, 32'h100, 1'b0, 1'b0, 32'h104},  // R6
    '{1'b1, 32'h100, 1'b1, 32'h800,  32'h104, 1'b1, 32'h100, 1'b1, 1'b1, 32'h800},  // R5 R2
    '{1'b1, 32'h100, 1'b0, 32'h0,    32'h800, 1'b1, 32'h100, 1'b1, 1'b0, 32'h104},  // R3
    '{1'b1, 32'h100, 1'b0, 32'h0,    32'h104, 1'b0, 32'h100, 1'b1, 1'b0, 32'h104},  // R7
    '{1'b1, 32'h100, 1'b0, 32'h0,    32'h104, 1'b0, 32'h100, 1'b1, 1'b0, 32'h104},  // R7 floor
    '{1'b1, 32'h100, 1'b1, 32'h800,  32'h104, 1'b1, 32'h100, 1'b1, 1'b0, 32'h104},  // R7 floor held
    '{1'b1, 32'h100, 1'b1, 32'h800,  32'h104, 1'b1, 32'h100, 1'b1, 1'b1, 32'h800},  // R7
    '{1'b1, 32'h100, 1'b1, 32'h900,  32'h800, 1'b1, 32'h100, 1'b1, 1'b1, 32'h900},  // R8
    '{1'b1, 32'h100, 1'b1, 32'h900,  32'h900, 1'b0, 32'h100, 1'b1, 1'b1, 32'h900},  // R7 ceiling
    '{1'b1, 32'h100, 1'b0, 32'h0,    32'h900, 1'b1, 32'h100, 1'b1, 1'b1, 32'h900},  // R7 ceiling held
    '{1'b0, 32'h0,   1'b0, 32'h0,    32'h0,   1'b0, 32'h140, 1'b0, 1'b0, 32'h144},  // R4
    '{1'b1, 32'h140, 1'b1, 32'hA00,  32'h144, 1'b1, 32'h100, 1'b0, 1'b0, 32'h104},  // R10
    '{1'b0, 32'h0,   1'b0, 32'h0,    32'h0,   1'b0, 32'h140, 1'b1, 1'b1, 32'hA00},  // R10
    '{1'b1, 32'h204, 1'b1, 32'h1000, 32'h208, 1'b1, 32'h204, 1'b1, 1'b1, 32'h1000}, // R5
    '{1'b0, 32'h0,   1'b0, 32'h0,    32'h0,   1'b0, 32'h140, 1'b1, 1'b1, 32'hA00},  // R4
    '{1'b1, 32'h308, 1'b0, 32'h0,    32'h30C, 1'b0, 32'h308, 1'b0, 1'b0, 32'h30C}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input string req, input logic [31:0] pc, input logic h,
                        input logic t, input logic [31:0] n);
    fetch_pc = pc;
    #0.5;
    check({req, " hit"}, {31'd0, pred_hit}, {31'd0, h});
    check({req, " taken"}, {31'd0, pred_taken}, {31'd0, t});
    check({req, " next"}, pred_next_pc, n);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_pc = 32'h0; upd_valid = 1'b0; upd_pc = 32'h0;
    upd_taken = 1'b0; upd_target = 32'h0; upd_pred_next = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: empty table after reset
    lookup("R1", 32'h100, 1'b0, 1'b0, 32'h104);
    lookup("R1", 32'h204, 1'b0, 1'b0, 32'h208);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      upd_valid = VECS[k].uv; upd_pc = VECS[k].upc; upd_taken = VECS[k].ut;
      upd_target = VECS[k].utgt; upd_pred_next = VECS[k].upn;
      #0.5;
      check($sformatf("R9 redirect v%0d", k), {31'd0, redirect}, {31'd0, VECS[k].rd});
      if (VECS[k].uv)
        check($sformatf("R9 redirect_pc v%0d", k), redirect_pc,
              VECS[k].ut ? VECS[k].utgt : VECS[k].upc + 32'd4);
      @(posedge clk);
      #1 upd_valid = 1'b0;
      lookup($sformatf("vec%0d", k), VECS[k].lpc, VECS[k].hit, VECS[k].tkn, VECS[k].nxt);
    end

    // R11: same-cycle lookup sees old contents, new contents after the edge
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h308; upd_taken = 1'b1;
    upd_target = 32'h2000; upd_pred_next = 32'h30C;
    lookup("R11 before edge", 32'h308, 1'b0, 1'b0, 32'h30C);
    @(posedge clk);
    #1 upd_valid = 1'b0;
    lookup("R11 after edge", 32'h308, 1'b1, 1'b1, 32'h2000);

    // R1: reset clears installed entries
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    lookup("R1 after reset", 32'h204, 1'b0, 1'b0, 32'h208);
    lookup("R1 after reset", 32'h140, 1'b0, 1'b0, 32'h144);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule